// File: doc/BRIEF.md
# Secondary Interrupt Aggregation Controller

This block collects 32 level-sensitive interrupt sources and presents them to a primary interrupt controller over 32 request lines. Every source level is registered once per clock. The levels that software has enabled are ORed into a single aggregate request on line 31. Sources 21 through 30 can each be connected straight to the primary line with the same number, so a driver can service them there without going through the aggregate.

Software controls the block through a small word-addressed register window of 4 KB. Enable bits use separate set and clear words, so a read-modify-write is never needed. A soft-interrupt word acts on enable bit 0 alone. All state clears on reset. Reads return data one clock after the read strobe.

Top module: `sic_aggregator`

## Requirements
- R1: After reset the enable mask and the route-enable vector are zero, every `parent_irq` line is low and `rdata` is zero.
- R2: `irq_in` is registered on every clock. A read of word 1 (byte offset 0x004) returns the registered source levels.
- R3: A write to word 2 (0x008) ORs `wdata` into the enable mask. A write to word 3 (0x00C) clears each mask bit that is 1 in `wdata`. A read of word 2 returns the mask.
- R4: A read of word 0 (0x000) returns the registered levels ANDed with the enable mask.
- R5: A read of word 4 (0x010) returns registered level bit 0 in bit 0, with every other bit zero. A nonzero write to word 4 sets mask bit 0, and a nonzero write to word 5 (0x014) clears it. A zero write to either word leaves the mask unchanged.
- R6: A write to word 8 (0x020) ORs `wdata & 0x7FE00000` into the route-enable vector, so only bits 21..30 can ever be set. A write to word 9 (0x024) clears the route bits that are 1 in `wdata`. A read of word 8 returns the vector.
- R7: `parent_irq[31]` is high exactly when (registered levels AND mask) is nonzero. It changes one clock after an `irq_in` change and in the same clock as the write that changes the mask.
- R8: For each i in 21..30 with its route bit set, `parent_irq[i]` equals registered level i, from the clock in which the route bit becomes set. With the route bit clear, the line holds its last value. Lines 0..20 stay low.
- R9: Bits [1:0] of `addr` are ignored. Reads of words other than 0, 1, 2, 4 and 8 return zero. Writes to words other than 2, 3, 4, 5, 8 and 9 change no state.
- R10: `rdata` is valid in the cycle after `rd_en` and is zero in any cycle that follows no read. A read in the same cycle as a write returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Source levels, synchronous to clk |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte offset within the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| parent_irq | output | 32 | Request lines toward the primary controller |

## Verification
A corrupted enable mask shows up on `parent_irq[31]` within one clock of the source or write that exposes it, and on the status readback one cycle after the read strobe. A route-enable bit stuck at the wrong value shows up as a routed line that fails to follow its source, or fails to hold its level, in the cycle after the source changes. A wrong address decode shows up as a nonzero readback from an unused word, or as a mask that changed after a write to an unused word. The bench makes each of these faults visible through `rdata` or `parent_irq`.

// File: rtl/sic_pkg.sv
package sic_pkg;

  // Widest register any instance may use; modules slice down to their width.
  localparam int SIC_MAXW = 64;

  // Word indices (byte offset >> 2). The numbering is software-visible.
  localparam int SIC_W_MASKED    = 0;
  localparam int SIC_W_RAW       = 1;
  localparam int SIC_W_EN_SET    = 2;
  localparam int SIC_W_EN_CLR    = 3;
  localparam int SIC_W_SOFT_SET  = 4;
  localparam int SIC_W_SOFT_CLR  = 5;
  localparam int SIC_W_ROUTE_SET = 8;
  localparam int SIC_W_ROUTE_CLR = 9;

  // Contiguous mask with bits lo..hi set.
  function automatic logic [SIC_MAXW-1:0] span_mask(input int lo, input int hi);
    logic [SIC_MAXW-1:0] m;
    m = '0;
    for (int b = 0; b < SIC_MAXW; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Write-one-to-set merge.
  function automatic logic [SIC_MAXW-1:0] w1s(input logic [SIC_MAXW-1:0] cur,
                                              input logic [SIC_MAXW-1:0] val,
                                              input logic [SIC_MAXW-1:0] allow);
    return cur | (val & allow);
  endfunction

  // Write-one-to-clear merge.
  function automatic logic [SIC_MAXW-1:0] w1c(input logic [SIC_MAXW-1:0] cur,
                                              input logic [SIC_MAXW-1:0] val);
    return cur & ~val;
  endfunction

endpackage

// File: rtl/sic_sampler.sv
// Registers the source levels once per clock.
module sic_sampler #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src_i,
  output logic [LINES-1:0] lvl_o
);

  logic [LINES-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= src_i;
  end

  assign lvl_o = lvl_q;

  // R2: the level register tracks the previous cycle's inputs
  a_r2_sample_track: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> lvl_q == $past(src_i));

endmodule

// File: rtl/sic_regfile.sv
// Register decode, enable mask, route-enable vector and read mux.
module sic_regfile
  import sic_pkg::*;
#(
  parameter int LINES    = 32,
  parameter int ADDR_W   = 12,
  parameter int ROUTE_LO = 21,
  parameter int ROUTE_HI = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  lvl_i,
  output logic [LINES-1:0]  mask_o,
  output logic [LINES-1:0]  route_en_o,
  output logic [LINES-1:0]  rdata_o
);

  localparam logic [SIC_MAXW-1:0] WIN_FULL  = span_mask(ROUTE_LO, ROUTE_HI);
  localparam logic [LINES-1:0]    ROUTE_WIN = WIN_FULL[LINES-1:0];
  localparam logic [SIC_MAXW-1:0] ALL_FULL  = span_mask(0, LINES-1);

  // Word index; the two byte-lane bits fall away in the shift.
  logic [ADDR_W-1:0] word_sel;
  assign word_sel = addr >> 2;

  // Named decode events.
  logic hit_en_set, hit_en_clr, hit_soft_set, hit_soft_clr;
  logic hit_route_set, hit_route_clr, wr_unmapped, wdata_nz;

  assign wdata_nz      = |wdata;
  assign hit_en_set    = wr_en && (word_sel == ADDR_W'(SIC_W_EN_SET));
  assign hit_en_clr    = wr_en && (word_sel == ADDR_W'(SIC_W_EN_CLR));
  assign hit_soft_set  = wr_en && (word_sel == ADDR_W'(SIC_W_SOFT_SET));
  assign hit_soft_clr  = wr_en && (word_sel == ADDR_W'(SIC_W_SOFT_CLR));
  assign hit_route_set = wr_en && (word_sel == ADDR_W'(SIC_W_ROUTE_SET));
  assign hit_route_clr = wr_en && (word_sel == ADDR_W'(SIC_W_ROUTE_CLR));
  assign wr_unmapped   = wr_en && !(hit_en_set || hit_en_clr || hit_soft_set ||
                                    hit_soft_clr || hit_route_set || hit_route_clr);

  logic [LINES-1:0] mask_q, mask_n;
  logic [LINES-1:0] route_q, route_n;
  logic [LINES-1:0] rd_val;
  logic [LINES-1:0] rdata_q;

  // Widened copies for the package helpers.
  logic [SIC_MAXW-1:0] mask_w, route_w, wdata_w;
  logic [SIC_MAXW-1:0] mask_set_w, mask_clr_w, route_set_w, route_clr_w;

  assign mask_w      = SIC_MAXW'(mask_q);
  assign route_w     = SIC_MAXW'(route_q);
  assign wdata_w     = SIC_MAXW'(wdata);
  assign mask_set_w  = w1s(mask_w, wdata_w, ALL_FULL);
  assign mask_clr_w  = w1c(mask_w, wdata_w);
  assign route_set_w = w1s(route_w, wdata_w, WIN_FULL);
  assign route_clr_w = w1c(route_w, wdata_w);

  always_comb begin
    mask_n = mask_q;
    if (hit_en_set)                 mask_n = mask_set_w[LINES-1:0];
    else if (hit_en_clr)            mask_n = mask_clr_w[LINES-1:0];
    else if (hit_soft_set && wdata_nz) mask_n[0] = 1'b1;
    else if (hit_soft_clr && wdata_nz) mask_n[0] = 1'b0;
  end

  always_comb begin
    route_n = route_q;
    if (hit_route_set)      route_n = route_set_w[LINES-1:0];
    else if (hit_route_clr) route_n = route_clr_w[LINES-1:0];
  end

  // Read mux: state before any same-cycle write.
  always_comb begin
    rd_val = '0;
    if (word_sel == ADDR_W'(SIC_W_MASKED))         rd_val = lvl_i & mask_q;
    else if (word_sel == ADDR_W'(SIC_W_RAW))       rd_val = lvl_i;
    else if (word_sel == ADDR_W'(SIC_W_EN_SET))    rd_val = mask_q;
    else if (word_sel == ADDR_W'(SIC_W_SOFT_SET))  rd_val[0] = lvl_i[0];
    else if (word_sel == ADDR_W'(SIC_W_ROUTE_SET)) rd_val = route_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_n;
      route_q <= route_n;
      rdata_q <= rd_en ? rd_val : '0;
    end
  end

  assign mask_o     = mask_q;
  assign route_en_o = route_q;
  assign rdata_o    = rdata_q;

  // R3: bits written through the set word are all present afterwards
  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en_set |=> (mask_q & $past(wdata)) == $past(wdata));

  // R3: bits written through the clear word are all gone afterwards
  a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en_clr |=> (mask_q & $past(wdata)) == '0);

  // R5: nonzero soft clear drops bit 0 and leaves the rest
  a_r5_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_soft_clr && wdata_nz) |=>
      (!mask_q[0] && mask_q[LINES-1:1] == $past(mask_q[LINES-1:1])));

  // R5: zero write to a soft word changes nothing
  a_r5_soft_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_soft_set || hit_soft_clr) && !wdata_nz) |=> $stable(mask_q));

  // R6: route bits outside the window never appear
  a_r6_route_window: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q & ~ROUTE_WIN) == '0);

  // R9: writes to unmapped words leave all state unchanged
  a_r9_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> ($stable(mask_q) && $stable(route_q)));

  // R10: an idle cycle leaves zero on the read bus
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata_q == '0);

endmodule

// File: rtl/sic_router.sv
// Builds the outgoing lines: routed window, aggregate line, low elsewhere.
module sic_router #(
  parameter int LINES    = 32,
  parameter int ROUTE_LO = 21,
  parameter int ROUTE_HI = 30,
  parameter int AGG_LINE = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] route_en_i,
  output logic [LINES-1:0] line_o
);

  logic any_pending;
  assign any_pending = |(lvl_i & mask_i);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == AGG_LINE) begin : g_agg
      assign line_o[i] = any_pending;
    end else if (i >= ROUTE_LO && i <= ROUTE_HI) begin : g_route
      logic held_q;
      // Track the routed level; frozen once routing is switched off.
      always_ff @(posedge clk) begin
        if (!rst_n)             held_q <= 1'b0;
        else if (route_en_i[i]) held_q <= lvl_i[i];
      end
      assign line_o[i] = route_en_i[i] ? lvl_i[i] : held_q;

      // R8: an unrouted line keeps its value from cycle to cycle
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!route_en_i[i] && $past(!route_en_i[i])) |-> $stable(line_o[i]));
    end else begin : g_idle
      assign line_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/sic_aggregator.sv
module sic_aggregator #(
  parameter int LINES    = 32,
  parameter int ADDR_W   = 12,
  parameter int ROUTE_LO = 21,
  parameter int ROUTE_HI = 30,
  parameter int AGG_LINE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  output logic [LINES-1:0]  rdata,
  output logic [LINES-1:0]  parent_irq
);

  logic [LINES-1:0] lvl;
  logic [LINES-1:0] mask;
  logic [LINES-1:0] route_en;

  sic_sampler #(.LINES(LINES)) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (irq_in),
    .lvl_o (lvl)
  );

  sic_regfile #(
    .LINES    (LINES),
    .ADDR_W   (ADDR_W),
    .ROUTE_LO (ROUTE_LO),
    .ROUTE_HI (ROUTE_HI)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .lvl_i      (lvl),
    .mask_o     (mask),
    .route_en_o (route_en),
    .rdata_o    (rdata)
  );

  sic_router #(
    .LINES    (LINES),
    .ROUTE_LO (ROUTE_LO),
    .ROUTE_HI (ROUTE_HI),
    .AGG_LINE (AGG_LINE)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl),
    .mask_i     (mask),
    .route_en_i (route_en),
    .line_o     (parent_irq)
  );

  logic rd_raw;
  assign rd_raw = rd_en && ((addr >> 2) == ADDR_W'(1));

  // R2: raw readback returns the sampled levels seen at the strobe
  a_r2_raw_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_raw |=> rdata == $past(lvl));

  // R7: aggregate line low whenever nothing is both pending and enabled
  a_r7_agg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl & mask) == '0) |-> !parent_irq[AGG_LINE]);

endmodule

// File: tb/tb_sic_aggregator.sv
module tb_sic_aggregator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] parent_irq;

  int checks = 0;
  int fails  = 0;

  // Requirement model (registers as software sees them)
  logic [31:0] m_raw = '0, m_mask = '0, m_route = '0;

  // Scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  sic_aggregator dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .parent_irq(parent_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a >> 2)
      0: return m_raw & m_mask;
      1: return m_raw;
      2: return m_mask;
      4: return {31'b0, m_raw[0]};
      8: return m_route;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    case (a >> 2)
      2: m_mask = m_mask | d;
      3: m_mask = m_mask & ~d;
      4: if (d != 0) m_mask[0] = 1'b1;
      5: if (d != 0) m_mask[0] = 1'b0;
      8: m_route = m_route | (d & 32'h7FE0_0000);
      9: m_route = m_route & ~d;
      default: ;
    endcase
  endfunction

  // Monitor: rdata checked at the falling edge after the read's capture edge
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R10 unexpected read data", rdata, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic set_irq(input logic [31:0] v);
    irq_in = v;
    @(negedge clk);
    m_raw = v;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 parent after reset", parent_irq, 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    rd(12'h008, "R1 mask after reset");
    rd(12'h020, "R1 route after reset");

    // R2 sampling, R4 status with empty mask, R7 quiet
    set_irq(32'h0000_00F5);
    rd(12'h004, "R2 raw readback");
    rd(12'h000, "R4 status empty mask");
    check("R7 aggregate low with no enables", parent_irq, 32'h0);

    // R3 enable set/clear, R4 status, R7 aggregate
    wr(12'h008, 32'h0000_0014);
    wr(12'h008, 32'h0000_0100);
    check("R7 aggregate high on enable", parent_irq, 32'h8000_0000);
    rd(12'h008, "R3 mask after two sets");
    rd(12'h000, "R4 status masked");
    wr(12'h00C, 32'h0000_0010);
    rd(12'h000, "R4 status after partial clear");
    wr(12'h00C, 32'h0000_0004);
    check("R7 aggregate low after clear", parent_irq, 32'h0);
    rd(12'h008, "R3 mask after clears");

    // R5 soft interrupt word
    rd(12'h010, "R5 soft read bit0 high");
    wr(12'h010, 32'h0);
    rd(12'h008, "R5 zero soft write ignored");
    wr(12'h010, 32'h0000_0080);
    check("R5 soft set raises aggregate", parent_irq, 32'h8000_0000);
    rd(12'h008, "R5 mask after soft set");
    wr(12'h014, 32'h0000_0002);
    check("R5 soft clear drops aggregate", parent_irq, 32'h0);
    rd(12'h008, "R5 mask after soft clear");
    set_irq(32'h0000_00F4);
    rd(12'h010, "R5 soft read bit0 low");

    // R9 unmapped and read-only words
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h028, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'hFFFF_FFFF);
    rd(12'h008, "R9 mask unchanged by unmapped writes");
    rd(12'h020, "R9 route unchanged by unmapped writes");
    rd(12'h018, "R9 unmapped read zero");
    rd(12'hFFC, "R9 top word read zero");
    rd(12'h00B, "R9 byte lane bits ignored");
    check("R9 lines unchanged", parent_irq, 32'h0);

    // R6 route window, R8 pass-through
    set_irq(32'h0060_0000);
    check("R8 unrouted sources stay low", parent_irq, 32'h0);
    wr(12'h020, 32'hFFFF_FFFF);
    check("R8 routing follows at once", parent_irq, 32'h0060_0000);
    rd(12'h020, "R6 route window only");
    set_irq(32'h4000_0001);
    check("R8 routed follow, line0 low", parent_irq, 32'h4000_0000);
    wr(12'h024, 32'h4000_0000);
    rd(12'h020, "R6 route clear");
    set_irq(32'h0);
    check("R8 unrouted line holds", parent_irq, 32'h4000_0000);
    set_irq(32'h8000_0000);
    wr(12'h008, 32'h8000_0000);
    check("R7 aggregate with held line", parent_irq, 32'hC000_0000);
    wr(12'h020, 32'h4000_0000);
    check("R8 re-route takes current level", parent_irq, 32'h8000_0000);

    // R10 read during write, idle zero
    exp_q.push_back(model_read(12'h008));
    tag_q.push_back("R10 read sees pre-write state");
    addr = 12'h008; wdata = 32'h1; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(12'h008, 32'h1);
    @(negedge clk);
    @(negedge clk);
    check("R10 rdata zero when idle", rdata, 32'h0);
    rd(12'h008, "R10 write landed");

    @(negedge clk);
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule